// File: doc/BRIEF.md
# Serial Flash Status Byte Guard

This block owns the two status bytes of a serial flash device and decides whether a request to rewrite them may go ahead. A command decoder presents one opcode per cycle on `cmd_op` with `cmd_valid`. With a status write it also presents a new pair of bytes on `cmd_data`, upper byte for the second status byte. Program and erase requests are handed to an external engine through `eng_start`. The engine reports the end of its work on `eng_done`. A status write runs through the same engine handshake, and its new bits take effect when that write completes.

The write gate combines the write-enable latch, a two-bit protect mode held in the status bytes, and the `wp_n` pin. The protect mode has four settings. The soft setting (00) gates only on the latch. The pin setting (01) also needs `wp_n` high. The session setting (10) blocks every status write until the next power cycle and then falls back to soft. The fused setting (11) blocks status writes for good. Three lock bits can be raised but never lowered. Each one marks a security register as read-only. A running program or erase can be paused and continued. A `pwr_cycle` pulse models a supply drop and return: every volatile bit is cleared, the session setting reverts, and the stored bits are kept.

The controller is a four-state machine with these states. ST_IDLE waits for commands. ST_ARRAY means a program or erase is running. ST_STATUS means a status write is running. ST_PAUSED means a program or erase is suspended. The named transitions are:
- take_array: ST_IDLE to ST_ARRAY.
- take_status: ST_IDLE to ST_STATUS.
- array_done: ST_ARRAY to ST_IDLE, on `eng_done`.
- status_done: ST_STATUS to ST_IDLE, on `eng_done`, with commit.
- pause: ST_ARRAY to ST_PAUSED.
- resume: ST_PAUSED to ST_ARRAY.
- power_drop: any state to ST_IDLE.

Top module: `flash_status_guard`

## Requirements
- R1: After `rst_n` is released, `sr1` and `sr2` read 0x00, and `wr_accept`, `eng_start` and `eng_hold` read 0.
- R2: `sr1` bit layout, from bit 7 down to bit 0: protect-mode low bit, sector-size select, top/bottom select, three block-protect bits (bits 4:2), write-enable latch (bit 1), write-in-progress (bit 0).
- R3: `sr2` bit layout, from bit 7 down to bit 0: suspended flag, complement-protect, lock bits 3..1 (bits 5:3), reserved (always 0), quad enable (bit 1), protect-mode high bit (bit 0).
- R4: In ST_IDLE or ST_PAUSED, opcode 0x06 sets the write-enable latch one cycle after the command, and opcode 0x04 clears it one cycle after the command.
- R5: Status write (0x01), program (0x02) and erase (0x20) requests are refused while the latch is 0. A refused request raises neither `wr_accept` nor `eng_start` and changes neither status byte.
- R6: An accepted request raises `wr_accept` and `eng_start` for exactly one cycle, in the cycle after the command. Write-in-progress then reads 1 until `eng_done` is seen. After that, write-in-progress and the latch read 0. For a status write, the new bits from `cmd_data` appear at that same moment.
- R7: With protect mode 00, a status write is accepted whatever `wp_n` is. With protect mode 01, it is refused while `wp_n` is 0 and accepted while `wp_n` is 1.
- R8: With protect mode 10, every status write is refused. A `pwr_cycle` pulse returns the mode to 00.
- R9: With protect mode 11, every status write is refused, and the mode survives `pwr_cycle`.
- R10: A lock bit that is 1 stays 1. Writing 0 to it has no effect.
- R11: A status write does not change write-in-progress, the latch, the suspended flag or the reserved bit, whatever `cmd_data` holds at those positions.
- R12: Opcode 0x75 during a program or erase moves the machine to ST_PAUSED. There the suspended flag and `eng_hold` read 1 and write-in-progress reads 0. While paused, `eng_done` and new status write, program or erase requests are ignored. Opcode 0x7A returns the machine to ST_ARRAY and clears the suspended flag.
- R13: A `pwr_cycle` pulse clears the latch, write-in-progress and the suspended flag, and abandons any operation without committing it. The stored bits keep their values, except for the session-mode revert.
- R14: While a program, erase or status write is running, every command except 0x75 (during a program or erase) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset to the blank state |
| pwr_cycle | input | 1 | One-cycle pulse modelling a supply drop and return |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | A command opcode is presented this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_data | input | 16 | New status bytes for 0x01, {second byte, first byte} |
| eng_done | input | 1 | Engine reports completion of the running operation |
| sr1 | output | 8 | First status byte |
| sr2 | output | 8 | Second status byte |
| wr_accept | output | 1 | One-cycle pulse when a write request is accepted |
| eng_start | output | 1 | One-cycle pulse starting the engine |
| eng_hold | output | 1 | Engine must stay paused |

## Verification
A wrong state is visible on `sr1[0]` and `sr2[7]` in the cycle after the edge that entered it. A wrong latch value shows up on `sr1[1]` in the same way. A wrong protect decision shows up one cycle after the command, as a missing or extra `wr_accept` pulse. A bad commit is a different matter. It does not appear until the `eng_done` that ends the status write, so the bench checks both bytes directly after every completion. The bench also follows each power cycle with a write attempt, so that a wrong stored mode turns into a wrong acceptance.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int OPW   = 8;
    localparam int SRW   = 8;
    localparam int LOCKS = 3;

    localparam logic [OPW-1:0] OP_WREN  = 8'h06;
    localparam logic [OPW-1:0] OP_WRDI  = 8'h04;
    localparam logic [OPW-1:0] OP_WRSR  = 8'h01;
    localparam logic [OPW-1:0] OP_PROG  = 8'h02;
    localparam logic [OPW-1:0] OP_ERASE = 8'h20;
    localparam logic [OPW-1:0] OP_SUSP  = 8'h75;
    localparam logic [OPW-1:0] OP_RESM  = 8'h7A;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARRAY  = 2'd1,
        ST_STATUS = 2'd2,
        ST_PAUSED = 2'd3
    } fsr_state_e;
endpackage

// File: rtl/fsr_gate.sv
module fsr_gate (
    input  logic [1:0] mode,
    input  logic       wp_n,
    input  logic       wel,
    output logic       wr_ok
);
    always_comb begin
        unique case (mode)
            2'b00:   wr_ok = wel;
            2'b01:   wr_ok = wel & wp_n;
            2'b10:   wr_ok = 1'b0;
            default: wr_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_cycle,
    input  logic           cmd_valid,
    input  logic [OPW-1:0] cmd_op,
    input  logic           eng_done,
    input  logic           st_ok,
    output logic           wel,
    output logic           wip,
    output logic           sus,
    output logic           wr_accept,
    output logic           eng_start,
    output logic           eng_hold,
    output logic           st_take,
    output logic           st_commit
);
    fsr_state_e state, nxt;
    logic       arr_take;
    logic       is_arr_op;

    assign is_arr_op = (cmd_op == OP_PROG) || (cmd_op == OP_ERASE);

    always_comb begin
        nxt      = state;
        st_take  = 1'b0;
        arr_take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && cmd_op == OP_WRSR && st_ok) begin
                    nxt     = ST_STATUS;
                    st_take = 1'b1;
                end else if (cmd_valid && is_arr_op && wel) begin
                    nxt      = ST_ARRAY;
                    arr_take = 1'b1;
                end
            end
            ST_ARRAY: begin
                if (eng_done)
                    nxt = ST_IDLE;
                else if (cmd_valid && cmd_op == OP_SUSP)
                    nxt = ST_PAUSED;
            end
            ST_STATUS: begin
                if (eng_done)
                    nxt = ST_IDLE;
            end
            ST_PAUSED: begin
                if (cmd_valid && cmd_op == OP_RESM)
                    nxt = ST_ARRAY;
            end
        endcase
        if (pwr_cycle) begin
            nxt      = ST_IDLE;
            st_take  = 1'b0;
            arr_take = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel       <= 1'b0;
            wr_accept <= 1'b0;
            eng_start <= 1'b0;
        end else begin
            wr_accept <= st_take | arr_take;
            eng_start <= st_take | arr_take;
            if (pwr_cycle)
                wel <= 1'b0;
            else if ((state == ST_ARRAY || state == ST_STATUS) && eng_done)
                wel <= 1'b0;
            else if (cmd_valid && (state == ST_IDLE || state == ST_PAUSED)) begin
                if (cmd_op == OP_WREN)
                    wel <= 1'b1;
                else if (cmd_op == OP_WRDI)
                    wel <= 1'b0;
            end
        end
    end

    assign wip       = (state == ST_ARRAY) || (state == ST_STATUS);
    assign sus       = (state == ST_PAUSED);
    assign eng_hold  = sus;
    assign st_commit = (state == ST_STATUS) && eng_done && !pwr_cycle;

    a_r5_accept_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> $past(wel));
    a_r6_wel_cleared_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && eng_done && !pwr_cycle) |=> !wel);
    a_r13_power_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |=> (!wel && !wip && !sus));
    a_r14_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> !$past(wip) && !$past(sus));
endmodule

// File: rtl/fsr_regs.sv
module fsr_regs
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_cycle,
    input  logic             st_take,
    input  logic             st_commit,
    input  logic [2*SRW-1:0] wr_data,
    output logic [SRW-3:0]   nv1,
    output logic             cmp,
    output logic [LOCKS-1:0] lock,
    output logic             qe,
    output logic             srp1
);
    logic [SRW-3:0]   pend1;
    logic             pend_cmp;
    logic [LOCKS-1:0] pend_lock;
    logic             pend_qe;
    logic             pend_srp1;
    logic             unused_bits;
    logic [1:0]       mode;

    assign unused_bits = ^{wr_data[15], wr_data[10], wr_data[1:0]};
    assign mode        = {srp1, nv1[SRW-3]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend1     <= '0;
            pend_cmp  <= 1'b0;
            pend_lock <= '0;
            pend_qe   <= 1'b0;
            pend_srp1 <= 1'b0;
        end else if (st_take) begin
            pend1     <= wr_data[SRW-1:2];
            pend_cmp  <= wr_data[14];
            pend_lock <= wr_data[13:11];
            pend_qe   <= wr_data[9];
            pend_srp1 <= wr_data[8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv1  <= '0;
            cmp  <= 1'b0;
            lock <= '0;
            qe   <= 1'b0;
            srp1 <= 1'b0;
        end else if (pwr_cycle) begin
            if (mode == 2'b10)
                srp1 <= 1'b0;
        end else if (st_commit) begin
            nv1  <= pend1;
            cmp  <= pend_cmp;
            lock <= lock | pend_lock;
            qe   <= pend_qe;
            srp1 <= pend_srp1;
        end
    end

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock & $past(lock)) == $past(lock)));
    a_r9_fused_mode_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (mode == 2'b11));
    a_r11_bits_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_commit && !pwr_cycle) |=> $stable({nv1, cmp, lock, qe, srp1}));
    a_r8_session_reverts: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cycle && mode == 2'b10) |=> (mode == 2'b00));
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
    import fsr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_cycle,
    input  logic         wp_n,
    input  logic         cmd_valid,
    input  logic [7:0]   cmd_op,
    input  logic [15:0]  cmd_data,
    input  logic         eng_done,
    output logic [7:0]   sr1,
    output logic [7:0]   sr2,
    output logic         wr_accept,
    output logic         eng_start,
    output logic         eng_hold
);
    logic             wel, wip, sus, st_ok, st_take, st_commit;
    logic [SRW-3:0]   nv1;
    logic             cmp, qe, srp1;
    logic [LOCKS-1:0] lock;

    fsr_gate u_gate (
        .mode  ({srp1, nv1[SRW-3]}),
        .wp_n  (wp_n),
        .wel   (wel),
        .wr_ok (st_ok)
    );

    fsr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_cycle (pwr_cycle),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .eng_done  (eng_done),
        .st_ok     (st_ok),
        .wel       (wel),
        .wip       (wip),
        .sus       (sus),
        .wr_accept (wr_accept),
        .eng_start (eng_start),
        .eng_hold  (eng_hold),
        .st_take   (st_take),
        .st_commit (st_commit)
    );

    fsr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_cycle (pwr_cycle),
        .st_take   (st_take),
        .st_commit (st_commit),
        .wr_data   (cmd_data),
        .nv1       (nv1),
        .cmp       (cmp),
        .lock      (lock),
        .qe        (qe),
        .srp1      (srp1)
    );

    assign sr1 = {nv1, wel, wip};
    assign sr2 = {sus, cmp, lock, 1'b0, qe, srp1};

    a_r7_pin_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRSR && {srp1, nv1[SRW-3]} == 2'b01 && !wp_n) |=> !wr_accept);
endmodule

// File: tb/flash_status_guard_tb_top.sv
`timescale 1ns/1ps
module flash_status_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_cycle = 1'b0;
    logic        wp_n = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic [15:0] cmd_data = 16'h0000;
    logic        eng_done = 1'b0;
    logic [7:0]  sr1, sr2;
    logic        wr_accept, eng_start, eng_hold;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    flash_status_guard dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .eng_done(eng_done), .sr1(sr1), .sr2(sr2), .wr_accept(wr_accept),
        .eng_start(eng_start), .eng_hold(eng_hold)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [15:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_data = 16'h0000;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic power_drop();
        @(negedge clk);
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sr1", {8'h0, sr1}, 16'h0000);
        chk("R1 sr2", {8'h0, sr2}, 16'h0000);
        chk("R1 pulses", {13'h0, wr_accept, eng_start, eng_hold}, 16'h0000);
    endtask

    task automatic t_latch();
        send(8'h06, 16'h0);
        chk("R4 R2 latch set", {8'h0, sr1}, 16'h0002);
        send(8'h04, 16'h0);
        chk("R4 latch clear", {8'h0, sr1}, 16'h0000);
    endtask

    task automatic t_no_latch();
        send(8'h01, 16'h00FC);
        chk("R5 wrsr refused", {14'h0, wr_accept, eng_start}, 16'h0000);
        send(8'h02, 16'h0);
        chk("R5 program refused", {14'h0, wr_accept, eng_start}, 16'h0000);
        send(8'h20, 16'h0);
        chk("R5 erase refused", {8'h0, sr1}, 16'h0000);
        done_pulse();
        chk("R5 bytes unchanged", {sr2, sr1}, 16'h0000);
    endtask

    task automatic t_status_write();
        send(8'h06, 16'h0);
        send(8'h01, 16'hCE3F);
        chk("R6 accept pulse", {14'h0, wr_accept, eng_start}, 16'h0003);
        chk("R6 busy before commit", {sr2, sr1}, 16'h0003);
        @(negedge clk);
        chk("R6 single pulse", {14'h0, wr_accept, eng_start}, 16'h0000);
        done_pulse();
        chk("R6 R11 R2 sr1 commit", {8'h0, sr1}, 16'h003C);
        chk("R3 R11 sr2 commit", {8'h0, sr2}, 16'h004A);
    endtask

    task automatic t_lock_sticky();
        send(8'h06, 16'h0);
        send(8'h01, 16'h0000);
        done_pulse();
        chk("R10 lock stays", {sr2, sr1}, 16'h0800);
    endtask

    task automatic t_pin_mode();
        send(8'h06, 16'h0);
        send(8'h01, 16'h0880);
        done_pulse();
        chk("R7 pin mode set", {sr2, sr1}, 16'h0880);
        wp_n = 1'b0;
        send(8'h06, 16'h0);
        send(8'h01, 16'h0800);
        chk("R7 pin low refused", {15'h0, wr_accept}, 16'h0000);
        chk("R7 bytes held", {sr2, sr1}, 16'h0882);
        wp_n = 1'b1;
        send(8'h01, 16'h0800);
        chk("R7 pin high accepted", {15'h0, wr_accept}, 16'h0001);
        done_pulse();
        wp_n = 1'b0;
        send(8'h06, 16'h0);
        send(8'h01, 16'h0804);
        chk("R7 soft mode ignores pin", {15'h0, wr_accept}, 16'h0001);
        done_pulse();
        chk("R7 soft result", {sr2, sr1}, 16'h0804);
        wp_n = 1'b1;
    endtask

    task automatic t_session_mode();
        send(8'h06, 16'h0);
        send(8'h01, 16'h0900);
        done_pulse();
        chk("R8 session set", {8'h0, sr2}, 16'h0009);
        send(8'h06, 16'h0);
        send(8'h01, 16'h0800);
        chk("R8 session refused", {15'h0, wr_accept}, 16'h0000);
        power_drop();
        chk("R8 R13 reverted", {sr2, sr1}, 16'h0800);
        send(8'h06, 16'h0);
        send(8'h01, 16'h0810);
        chk("R8 soft after drop", {15'h0, wr_accept}, 16'h0001);
        done_pulse();
        chk("R8 new bytes", {sr2, sr1}, 16'h0810);
    endtask

    task automatic t_suspend();
        send(8'h06, 16'h0);
        send(8'h02, 16'h0);
        chk("R6 program accepted", {7'h0, wr_accept, sr1}, 16'h0113);
        send(8'h75, 16'h0);
        chk("R12 paused", {7'h0, eng_hold, sr2, sr1}[15:0], {sr2, sr1} == 16'h8812 && eng_hold ? {8'h88, 8'h12} : 16'hFFFF);
        chk("R12 paused bytes", {sr2, sr1}, 16'h8812);
        send(8'h01, 16'h0000);
        chk("R12 write refused when paused", {15'h0, wr_accept}, 16'h0000);
        done_pulse();
        chk("R12 done ignored when paused", {sr2, sr1}, 16'h8812);
        send(8'h7A, 16'h0);
        chk("R12 resumed", {7'h0, eng_hold, sr1}, 16'h0013);
        chk("R12 flag cleared", {8'h0, sr2}, 16'h0008);
        done_pulse();
        chk("R6 program done", {8'h0, sr1}, 16'h0010);
    endtask

    task automatic t_busy_ignore();
        send(8'h06, 16'h0);
        send(8'h20, 16'h0);
        send(8'h04, 16'h0);
        chk("R14 wrdi ignored", {8'h0, sr1}, 16'h0013);
        send(8'h75, 16'h0);
        send(8'h7A, 16'h0);
        done_pulse();
        chk("R14 erase done", {8'h0, sr1}, 16'h0010);
        send(8'h06, 16'h0);
        send(8'h01, 16'h0800);
        send(8'h75, 16'h0);
        chk("R14 no pause in status write", {8'h0, sr2}, 16'h0008);
        done_pulse();
        chk("R14 status write done", {sr2, sr1}, 16'h0800);
    endtask

    task automatic t_drop_abort();
        send(8'h06, 16'h0);
        send(8'h01, 16'h0810);
        power_drop();
        chk("R13 aborted", {sr2, sr1}, 16'h0800);
        done_pulse();
        chk("R13 no late commit", {sr2, sr1}, 16'h0800);
    endtask

    task automatic t_fused_mode();
        send(8'h06, 16'h0);
        send(8'h01, 16'h0980);
        done_pulse();
        chk("R9 fused set", {sr2, sr1}, 16'h0980);
        send(8'h06, 16'h0);
        send(8'h01, 16'h0800);
        chk("R9 refused", {15'h0, wr_accept}, 16'h0000);
        power_drop();
        chk("R9 survives drop", {sr2, sr1}, 16'h0980);
        send(8'h06, 16'h0);
        send(8'h01, 16'h0800);
        chk("R9 refused after drop", {15'h0, wr_accept}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_latch();
        t_status_write();
        t_lock_sticky();
        t_pin_mode();
        t_session_mode();
        t_suspend();
        t_busy_ignore();
        t_drop_abort();
        t_fused_mode();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule